// File: doc/BRIEF.md
# Reconfigurable Region Load Manager

This block keeps the bookkeeping for a small pool of reconfigurable regions and decides where each incoming hardware-task load request goes. Each request carries a task identifier and two flags. The first flag says whether the new configuration passed its signature check. The second says whether the task also has a software implementation. The block tries the following in order:

- reuse a region that already holds the task and is idle;
- claim a free region and start configuring it, but only when the signature check passed;
- send the request to software;
- park the request as the single pending reservation.

Each region runs its own four-state machine. The states are **EMPTY**, **CONFIG** (configuring), **EXEC** (executing) and **IDLE** (loaded, not running). The transitions are:

- **load**: EMPTY or IDLE to CONFIG.
- **cfg_done**: CONFIG to IDLE.
- **start**: IDLE to EXEC.
- **exec_done**: EXEC to IDLE.

The reservation has its own two-state machine. **RS_NONE** goes to **RS_HELD** on *reserve*. **RS_HELD** goes back to **RS_NONE** on *grant*. The environment reports configuration completion and execution completion per region. Every decision is reported as a one-cycle outcome pulse. Three running counters track signature validations: how many were performed, how many passed and how many failed.

Top module: `rrm_manager`

## Requirements
- R1: While reset is asserted and afterwards, until the first accepted request:
  - all regions read EMPTY with task ID 0;
  - all three counters read 0;
  - no reservation is held;
  - `req_ready` is 1.
- R2: Region i reports its state on `region_state[2i+1:2i]`, encoded EMPTY=0, CONFIG=1, EXEC=2, IDLE=3. It reports its task ID on `region_task[8i+7:8i]`.
- R3: When a request names a task held by an IDLE region, the lowest-indexed such region goes to EXEC with its task ID kept. The outcome is HIT (code 0) with that region's index, and no counter changes.
- R4: Without a hit, the target region is the lowest-indexed EMPTY region. If no region is EMPTY, it is the lowest-indexed IDLE region.
- R5: With a target region and the signature flag set, the target goes to CONFIG with the requested task ID. The outcome is LOAD (code 1) with the target index. The total and pass counters each increase by one.
- R6: With a target region and the signature flag clear, the target's state and task ID do not change. The outcome is REJECT (code 2) with the target index. The total and fail counters each increase by one.
- R7: `cfg_done[i]` moves region i from CONFIG to IDLE and has no effect in any other state.
- R8: `exec_done[i]` moves region i from EXEC to IDLE and has no effect in any other state.
- R9: When no region is EMPTY or IDLE and the software flag is set, the outcome is SW (code 3) with region index 0. No region changes and no counter changes.
- R10: When no region is EMPTY or IDLE and the software flag is clear, the request is stored:
  - the outcome is RESERVED (code 4) with region index 0;
  - `resv_valid` rises and `resv_task` shows the task;
  - `req_ready` stays 0 while the reservation is held.
- R11: In the first cycle that a reservation is held and some region is EMPTY or IDLE, the reservation is served by the rules of R3 to R6, using its stored signature flag. The outcome carries `out_resv`=1 and the reservation is cleared.
- R12: An accepted request or a granted reservation produces an outcome pulse in the cycle after the accepting clock edge. The region updates and counter updates take effect at that same edge. With no decision, `out_valid` is 0.
- R13: The total counter always equals the pass count plus the fail count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Load request present |
| req_ready | output | 1 | Request can be accepted (no reservation held) |
| req_task | input | 8 | Requested task ID |
| req_sig_ok | input | 1 | Signature validation of the new configuration succeeded |
| req_has_sw | input | 1 | Task has a software fallback |
| cfg_done | input | 4 | Per-region configuration complete |
| exec_done | input | 4 | Per-region execution complete |
| region_state | output | 8 | Packed per-region state |
| region_task | output | 32 | Packed per-region task ID |
| out_valid | output | 1 | Outcome pulse |
| out_code | output | 3 | Outcome code |
| out_region | output | 2 | Region the outcome refers to |
| out_resv | output | 1 | Outcome belongs to a granted reservation |
| resv_valid | output | 1 | Reservation held |
| resv_task | output | 8 | Task ID of the held reservation |
| val_total | output | 16 | Validations performed |
| val_pass | output | 16 | Validations passed |
| val_fail | output | 16 | Validations failed |

## Verification
Every result of a decision becomes visible one clock edge after the request is accepted, or one edge after the cycle in which a free region is observed for a held reservation. These results are the outcome pulse, the region state and task ID, the counters and the reservation flag. A completion input moves its region at the very next edge. The bench drives inputs on the falling edge and advances its model one step. It then compares every output on the following falling edge, so each check lands exactly one register stage after its stimulus.

// File: rtl/rrm_pkg.sv
package rrm_pkg;
    typedef enum logic [1:0] {
        RG_EMPTY  = 2'd0,
        RG_CONFIG = 2'd1,
        RG_EXEC   = 2'd2,
        RG_IDLE   = 2'd3
    } rg_state_e;

    typedef enum logic [2:0] {
        OC_HIT      = 3'd0,
        OC_LOAD     = 3'd1,
        OC_REJECT   = 3'd2,
        OC_SW       = 3'd3,
        OC_RESERVED = 3'd4
    } outcome_e;

    typedef enum logic {
        RS_NONE = 1'b0,
        RS_HELD = 1'b1
    } resv_state_e;
endpackage

// File: rtl/rrm_region.sv
module rrm_region
    import rrm_pkg::*;
#(
    parameter int TASK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [TASK_W-1:0] new_task_i,
    input  logic              start_i,
    input  logic              cfg_done_i,
    input  logic              exec_done_i,
    output rg_state_e         state_o,
    output logic [TASK_W-1:0] task_o
);
    rg_state_e         st_q, st_d;
    logic [TASK_W-1:0] tk_q, tk_d;

    always_comb begin
        st_d = st_q;
        tk_d = tk_q;
        unique case (st_q)
            RG_EMPTY: begin
                if (load_i) begin
                    st_d = RG_CONFIG;
                    tk_d = new_task_i;
                end
            end
            RG_CONFIG: begin
                if (cfg_done_i) st_d = RG_IDLE;
            end
            RG_EXEC: begin
                if (exec_done_i) st_d = RG_IDLE;
            end
            RG_IDLE: begin
                if (load_i) begin
                    st_d = RG_CONFIG;
                    tk_d = new_task_i;
                end else if (start_i) begin
                    st_d = RG_EXEC;
                end
            end
            default: st_d = RG_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= RG_EMPTY;
            tk_q <= '0;
        end else begin
            st_q <= st_d;
            tk_q <= tk_d;
        end
    end

    always_comb begin
        state_o = st_q;
        task_o  = tk_q;
    end

    // R7: configuration completion leads to idle
    p_cfg_to_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == RG_CONFIG && cfg_done_i) |=> (st_q == RG_IDLE));
    // R8: execution completion leads back to idle
    p_exec_to_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == RG_EXEC && exec_done_i) |=> (st_q == RG_IDLE));
    // R3: a start command only reaches an idle region
    p_start_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> (st_q == RG_IDLE));
    // R4: a load only targets an empty or idle region
    p_load_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> (st_q == RG_EMPTY || st_q == RG_IDLE));
endmodule

// File: rtl/rrm_picker.sv
module rrm_picker
    import rrm_pkg::*;
#(
    parameter int NREG   = 4,
    parameter int TASK_W = 8,
    parameter int IDX_W  = 2
) (
    input  logic [2*NREG-1:0]      states_i,
    input  logic [NREG*TASK_W-1:0] tasks_i,
    input  logic [TASK_W-1:0]      key_i,
    output logic                   hit_o,
    output logic [IDX_W-1:0]       hit_idx_o,
    output logic                   free_o,
    output logic [IDX_W-1:0]       free_idx_o
);
    logic             emp_f, idl_f;
    logic [IDX_W-1:0] emp_i, idl_i;

    always_comb begin
        hit_o     = 1'b0;
        hit_idx_o = '0;
        emp_f     = 1'b0;
        emp_i     = '0;
        idl_f     = 1'b0;
        idl_i     = '0;
        for (int i = NREG - 1; i >= 0; i--) begin
            if (states_i[2*i +: 2] == 2'(RG_IDLE)) begin
                idl_f = 1'b1;
                idl_i = IDX_W'(i);
                if (tasks_i[TASK_W*i +: TASK_W] == key_i) begin
                    hit_o     = 1'b1;
                    hit_idx_o = IDX_W'(i);
                end
            end
            if (states_i[2*i +: 2] == 2'(RG_EMPTY)) begin
                emp_f = 1'b1;
                emp_i = IDX_W'(i);
            end
        end
        free_o     = emp_f | idl_f;
        free_idx_o = emp_f ? emp_i : idl_i;
    end
endmodule

// File: rtl/rrm_counters.sv
module rrm_counters #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_pass_i,
    input  logic             inc_fail_i,
    output logic [CNT_W-1:0] total_o,
    output logic [CNT_W-1:0] pass_o,
    output logic [CNT_W-1:0] fail_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            total_o <= '0;
            pass_o  <= '0;
            fail_o  <= '0;
        end else begin
            if (inc_pass_i || inc_fail_i) total_o <= total_o + 1'b1;
            if (inc_pass_i) pass_o <= pass_o + 1'b1;
            if (inc_fail_i) fail_o <= fail_o + 1'b1;
        end
    end

    // R13: totals consistent with pass and fail counts
    p_sum_r13: assert property (@(posedge clk) disable iff (!rst_n)
        total_o == CNT_W'(pass_o + fail_o));
    // R6: a validation either passes or fails, never both
    p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(inc_pass_i && inc_fail_i));
endmodule

// File: rtl/rrm_manager.sv
module rrm_manager
    import rrm_pkg::*;
#(
    parameter int NREG   = 4,
    parameter int TASK_W = 8,
    parameter int CNT_W  = 16,
    localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [TASK_W-1:0]      req_task,
    input  logic                   req_sig_ok,
    input  logic                   req_has_sw,
    input  logic [NREG-1:0]        cfg_done,
    input  logic [NREG-1:0]        exec_done,
    output logic [2*NREG-1:0]      region_state,
    output logic [NREG*TASK_W-1:0] region_task,
    output logic                   out_valid,
    output logic [2:0]             out_code,
    output logic [IDX_W-1:0]       out_region,
    output logic                   out_resv,
    output logic                   resv_valid,
    output logic [TASK_W-1:0]      resv_task,
    output logic [CNT_W-1:0]       val_total,
    output logic [CNT_W-1:0]       val_pass,
    output logic [CNT_W-1:0]       val_fail
);
    resv_state_e rs_q, rs_d;
    logic [TASK_W-1:0] rtask_q;
    logic              rsig_q;

    logic              use_resv, go;
    logic [TASK_W-1:0] src_task;
    logic              src_sig, src_sw;
    logic              hit, free;
    logic [IDX_W-1:0]  hit_idx, free_idx;

    logic              do_load, do_start, do_reserve, inc_pass, inc_fail;
    logic [IDX_W-1:0]  tgt_idx;
    outcome_e          code_d;

    rg_state_e         st_arr [NREG];
    logic [NREG-1:0]   load_vec, start_vec;

    logic              ov_q, or_q;
    outcome_e          oc_q;
    logic [IDX_W-1:0]  oi_q;

    // request source: a held reservation takes precedence
    always_comb begin
        use_resv = (rs_q == RS_HELD);
        src_task = use_resv ? rtask_q : req_task;
        src_sig  = use_resv ? rsig_q  : req_sig_ok;
        src_sw   = use_resv ? 1'b0    : req_has_sw;
        go       = use_resv ? free    : req_valid;
    end

    rrm_picker #(.NREG(NREG), .TASK_W(TASK_W), .IDX_W(IDX_W)) u_pick (
        .states_i  (region_state),
        .tasks_i   (region_task),
        .key_i     (src_task),
        .hit_o     (hit),
        .hit_idx_o (hit_idx),
        .free_o    (free),
        .free_idx_o(free_idx)
    );

    // decision logic
    always_comb begin
        do_load    = 1'b0;
        do_start   = 1'b0;
        do_reserve = 1'b0;
        inc_pass   = 1'b0;
        inc_fail   = 1'b0;
        tgt_idx    = '0;
        code_d     = OC_SW;
        if (go) begin
            if (hit) begin
                do_start = 1'b1;
                tgt_idx  = hit_idx;
                code_d   = OC_HIT;
            end else if (free) begin
                tgt_idx = free_idx;
                if (src_sig) begin
                    do_load  = 1'b1;
                    inc_pass = 1'b1;
                    code_d   = OC_LOAD;
                end else begin
                    inc_fail = 1'b1;
                    code_d   = OC_REJECT;
                end
            end else if (src_sw) begin
                code_d = OC_SW;
            end else begin
                do_reserve = 1'b1;
                code_d     = OC_RESERVED;
            end
        end
    end

    // reservation state machine: next state
    always_comb begin
        rs_d = rs_q;
        unique case (rs_q)
            RS_NONE: if (do_reserve) rs_d = RS_HELD;
            RS_HELD: if (go) rs_d = RS_NONE;
            default: rs_d = RS_NONE;
        endcase
    end

    // state and outcome registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rs_q    <= RS_NONE;
            rtask_q <= '0;
            rsig_q  <= 1'b0;
            ov_q    <= 1'b0;
            oc_q    <= OC_HIT;
            oi_q    <= '0;
            or_q    <= 1'b0;
        end else begin
            rs_q <= rs_d;
            if (do_reserve) begin
                rtask_q <= req_task;
                rsig_q  <= req_sig_ok;
            end
            ov_q <= go;
            if (go) begin
                oc_q <= code_d;
                oi_q <= tgt_idx;
                or_q <= use_resv;
            end
        end
    end

    // outputs
    always_comb begin
        req_ready  = (rs_q == RS_NONE);
        resv_valid = (rs_q == RS_HELD);
        resv_task  = rtask_q;
        out_valid  = ov_q;
        out_code   = ov_q ? 3'(oc_q) : 3'd0;
        out_region = ov_q ? oi_q : '0;
        out_resv   = ov_q & or_q;
    end

    generate
        for (genvar g = 0; g < NREG; g++) begin : g_reg
            assign load_vec[g]  = do_load  && (tgt_idx == IDX_W'(g));
            assign start_vec[g] = do_start && (tgt_idx == IDX_W'(g));
            rrm_region #(.TASK_W(TASK_W)) u_region (
                .clk        (clk),
                .rst_n      (rst_n),
                .load_i     (load_vec[g]),
                .new_task_i (src_task),
                .start_i    (start_vec[g]),
                .cfg_done_i (cfg_done[g]),
                .exec_done_i(exec_done[g]),
                .state_o    (st_arr[g]),
                .task_o     (region_task[TASK_W*g +: TASK_W])
            );
            assign region_state[2*g +: 2] = st_arr[g];
        end
    endgenerate

    rrm_counters #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .inc_pass_i(inc_pass),
        .inc_fail_i(inc_fail),
        .total_o   (val_total),
        .pass_o    (val_pass),
        .fail_o    (val_fail)
    );

    // R4: at most one region commanded per cycle
    p_one_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(load_vec | start_vec));
    // R3: a hit outcome shows its region executing
    p_hit_exec_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_code == 3'(OC_HIT)) |-> (st_arr[out_region] == RG_EXEC));
    // R5: a load outcome shows its region configuring
    p_load_cfg_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_code == 3'(OC_LOAD)) |-> (st_arr[out_region] == RG_CONFIG));
    // R6: a rejected load leaves every task ID untouched
    p_reject_task_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_code == 3'(OC_REJECT)) |-> $stable(region_task));
    // R10: a reserved outcome leaves the reservation held
    p_resv_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_code == 3'(OC_RESERVED)) |-> resv_valid);
    // R11: a granted reservation is gone after its outcome
    p_grant_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        out_resv |-> !resv_valid);
endmodule

// File: tb/rrm_manager_test.sv
module rrm_manager_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_sig_ok, req_has_sw;
    logic [7:0]  req_task;
    logic [3:0]  cfg_done, exec_done;
    logic        req_ready, out_valid, out_resv, resv_valid;
    logic [7:0]  region_state, resv_task;
    logic [31:0] region_task;
    logic [2:0]  out_code;
    logic [1:0]  out_region;
    logic [15:0] val_total, val_pass, val_fail;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 0;

    // model
    int   m_st [4];
    int   m_tk [4];
    int   m_tot, m_pas, m_fal;
    bit   m_rv, m_rs;
    int   m_rt;
    bit   e_ov, e_or;
    int   e_code, e_reg;

    always #10 clk = ~clk;

    rrm_manager uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_task(req_task), .req_sig_ok(req_sig_ok), .req_has_sw(req_has_sw),
        .cfg_done(cfg_done), .exec_done(exec_done), .region_state(region_state),
        .region_task(region_task), .out_valid(out_valid), .out_code(out_code),
        .out_region(out_region), .out_resv(out_resv), .resv_valid(resv_valid),
        .resv_task(resv_task), .val_total(val_total), .val_pass(val_pass),
        .val_fail(val_fail)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
        end
    endtask

    function automatic string code_tag(input int c);
        case (c)
            0: return "R3 hit";
            1: return "R5 load";
            2: return "R6 reject";
            3: return "R9 software";
            default: return "R10 reserved";
        endcase
    endfunction

    task automatic compare_all();
        chk("R10 req_ready", int'(req_ready), int'(!m_rv));
        chk("R10 resv_valid", int'(resv_valid), int'(m_rv));
        if (m_rv) chk("R10 resv_task", int'(resv_task), m_rt);
        for (int i = 0; i < 4; i++) begin
            chk("R2/R7/R8 region state", int'(region_state[2*i +: 2]), m_st[i]);
            chk("R2 region task", int'(region_task[8*i +: 8]), m_tk[i]);
        end
        chk("R12 out_valid", int'(out_valid), int'(e_ov));
        if (e_ov) begin
            chk(code_tag(e_code), int'(out_code), e_code);
            chk("R4 out_region", int'(out_region), e_reg);
            chk("R11 out_resv", int'(out_resv), int'(e_or));
        end
        chk("R13 val_total", int'(val_total), m_tot);
        chk("R5 val_pass", int'(val_pass), m_pas);
        chk("R6 val_fail", int'(val_fail), m_fal);
    endtask

    task automatic model_step(input bit v, input int tk, input bit sg, input bit sw,
                              input logic [3:0] cd, input logic [3:0] ed);
        int hit = -1, fe = -1, fi = -1, fr;
        int nst [4];
        int t;
        bit s, w, go, fromr;
        fromr = m_rv;
        t = m_rv ? m_rt : tk;
        s = m_rv ? m_rs : sg;
        w = m_rv ? 1'b0 : sw;
        for (int i = 0; i < 4; i++) begin
            if (hit < 0 && m_st[i] == 3 && m_tk[i] == t) hit = i;
            if (fe < 0 && m_st[i] == 0) fe = i;
            if (fi < 0 && m_st[i] == 3) fi = i;
        end
        fr = (fe >= 0) ? fe : fi;
        go = m_rv ? (fr >= 0) : v;
        for (int i = 0; i < 4; i++) begin
            nst[i] = m_st[i];
            if (m_st[i] == 1 && cd[i]) nst[i] = 3;
            if (m_st[i] == 2 && ed[i]) nst[i] = 3;
        end
        e_ov = go;
        e_or = fromr;
        if (go) begin
            if (hit >= 0) begin
                nst[hit] = 2; e_code = 0; e_reg = hit;
            end else if (fr >= 0) begin
                e_reg = fr;
                m_tot++;
                if (s) begin
                    nst[fr] = 1; m_tk[fr] = t; m_pas++; e_code = 1;
                end else begin
                    m_fal++; e_code = 2;
                end
            end else begin
                e_reg = 0;
                if (w) e_code = 3;
                else begin
                    e_code = 4; m_rv = 1; m_rt = t; m_rs = s;
                end
            end
            if (fromr) m_rv = 0;
        end
        for (int i = 0; i < 4; i++) m_st[i] = nst[i];
    endtask

    task automatic apply(input bit v, input int tk, input bit sg, input bit sw,
                         input logic [3:0] cd, input logic [3:0] ed);
        req_valid  = v;
        req_task   = 8'(tk);
        req_sig_ok = sg;
        req_has_sw = sw;
        cfg_done   = cd;
        exec_done  = ed;
        model_step(v, tk, sg, sw, cd, ed);
        @(negedge clk);
        cyc++;
        compare_all();
    endtask

    always @(posedge clk) begin
        if (!done && cyc > 100000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 100000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0;
        req_valid = 0; req_task = 0; req_sig_ok = 0; req_has_sw = 0;
        cfg_done = 0; exec_done = 0;
        for (int i = 0; i < 4; i++) begin m_st[i] = 0; m_tk[i] = 0; end
        m_tot = 0; m_pas = 0; m_fal = 0; m_rv = 0; m_rs = 0; m_rt = 0;
        e_ov = 0; e_or = 0; e_code = 0; e_reg = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare_all();               // R1 during reset
        rst_n = 1'b1;
        @(negedge clk);
        compare_all();               // R1 after reset release
        // directed corner cases
        apply(1, 5, 1, 0, 4'b0000, 4'b0000);   // R5 load into region 0
        apply(1, 6, 0, 0, 4'b0000, 4'b0000);   // R6 reject, target region 1
        apply(1, 7, 1, 0, 4'b1111, 4'b1111);   // R7 cfg_done ignored on empty, R8 ignored
        apply(1, 5, 0, 0, 4'b0000, 4'b0000);   // R3 hit region 0, no validation
        apply(1, 8, 1, 0, 4'b0000, 4'b0000);   // R4 region 2
        apply(1, 9, 1, 0, 4'b0000, 4'b0000);   // R4 region 3
        apply(1, 10, 1, 1, 4'b0000, 4'b0000);  // R9 software fallback
        apply(1, 11, 1, 0, 4'b0000, 4'b0000);  // R10 reservation
        apply(1, 12, 1, 1, 4'b0000, 4'b0000);  // R10 ready low, request ignored
        apply(0, 0, 0, 0, 4'b0000, 4'b0001);   // R8 region 0 back to idle
        apply(0, 0, 0, 0, 4'b0000, 4'b0000);   // R11 grant into region 0
        apply(0, 0, 0, 0, 4'b1111, 4'b0000);   // R7 configs complete
        apply(1, 11, 1, 0, 4'b0000, 4'b0000);  // R3 hit on granted task
        // constrained random
        for (int k = 0; k < 4000; k++) begin
            apply(($urandom % 2) == 0, 1 + ($urandom % 6), ($urandom % 4) != 0,
                  ($urandom % 2) == 0,
                  4'({($urandom % 6) == 0, ($urandom % 6) == 0, ($urandom % 6) == 0, ($urandom % 6) == 0}),
                  4'({($urandom % 6) == 0, ($urandom % 6) == 0, ($urandom % 6) == 0, ($urandom % 6) == 0}));
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule